// File: doc/BRIEF.md
# Interrupt Request Capture for a Paired Eight-Line Controller

This block is the input side of two cascaded eight-input interrupt controllers that together serve sixteen request lines. Each line can be driven by several sources at once. The block therefore keeps a saturating count of how many sources currently assert the line, rather than one wire level. Events arrive one per cycle as a strobe that carries a line number and an event kind: assert, deassert, or pulse. A pulse is an assert followed at once by a deassert.

From the count and from a per-line trigger mode (edge or level), the block sets bits in the request vector of the owning controller. Acknowledge logic downstream names a line to clear. An edge request is consumed by that acknowledge. A level request survives while any source still holds the line. The two trigger-mode registers are byte-wide and are written and read through a simple select port. A few lines in each register are wired to edge mode. Events aimed at a controller whose ready input is low are dropped.

Top module: `irq_req_capture`

## Requirements
- R1: After reset every request bit, every underflow flag, every line count and both trigger-mode registers are zero.
- R2: Line n belongs to controller n/8, bit n mod 8. Its request appears on req_o bit n, and its events are gated by ctl_ready bit n/8.
- R3: In edge mode an assert raises the line's request only when the count was zero before it. An assert that finds the count above zero raises nothing.
- R4: A deassert that brings the count from one to zero raises no request and leaves an existing request untouched.
- R5: In level mode (mode bit 1) an assert or a pulse always raises the request. An acknowledge does not clear it while the count is above zero.
- R6: A pulse leaves the count unchanged. In edge mode it raises the request only if the count was zero.
- R7: The count saturates at 15. A deassert at count zero keeps the count at zero and sets that line's sticky bit in uf_err_o.
- R8: Controller 0 mode register: written bits 0, 1 and 2 always read back 0. Controller 1 mode register: written bits 0 and 5 always read back 0. These are lines 0, 1, 2, 8 and 13, which stay edge-triggered.
- R9: mode_rdata shows, in the same cycle, the mode register chosen by mode_rsel (0 for controller 0, 1 for controller 1).
- R10: An event on a line whose controller has ctl_ready low changes neither the count nor the request.
- R11: An acknowledge on a line clears its request when the line is in edge mode or its count is zero. If an event raises the same line's request in the same cycle, the raise wins.
- R12: Event kind encoding: 2'b01 assert, 2'b10 deassert, 2'b11 pulse, 2'b00 no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_ready | input | 2 | Per-controller initialized flag |
| evt_valid | input | 1 | Event strobe |
| evt_line | input | 4 | Line number of the event |
| evt_kind | input | 2 | Event kind (R12) |
| ack_valid | input | 1 | Acknowledge-clear strobe |
| ack_line | input | 4 | Line to clear |
| mode_we | input | 1 | Trigger-mode register write enable |
| mode_wsel | input | 1 | Register chosen for the write |
| mode_wdata | input | 8 | Write data, bit set means level |
| mode_rsel | input | 1 | Register chosen for the read |
| mode_rdata | output | 8 | Read data |
| req_o | output | 16 | Request bits, controller 1 in the upper byte |
| uf_err_o | output | 16 | Sticky per-line count underflow flags |

## Verification
The bench builds the block with its default parameters: two controllers of eight lines, 4-bit counts, and edge-only lines 0, 1, 2, 8 and 13. With a 4-bit count, saturation at 15 can be reached in sixteen events. That makes the difference between saturating and wrapping visible through a later underflow flag and a later rising edge. The small line count lets the vector table touch the lowest and highest line of both controllers and the forced-edge bits of both mode registers.

// File: rtl/irq_cap_pkg.sv
package irq_cap_pkg;
    typedef enum logic [1:0] {
        EV_NONE     = 2'b00,
        EV_ASSERT   = 2'b01,
        EV_DEASSERT = 2'b10,
        EV_PULSE    = 2'b11
    } ev_kind_e;
endpackage

// File: rtl/irq_evt_decode.sv
module irq_evt_decode #(
    parameter int N_CTL = 2,
    parameter int LINES = 8,
    localparam int NL = N_CTL * LINES,
    localparam int LW = $clog2(NL)
) (
    input  logic [N_CTL-1:0] ctl_ready,
    input  logic             evt_valid,
    input  logic [LW-1:0]    evt_line,
    input  logic             ack_valid,
    input  logic [LW-1:0]    ack_line,
    output logic [NL-1:0]    evt_hit,
    output logic [NL-1:0]    ack_hit
);
    for (genvar n = 0; n < NL; n++) begin : g_line
        localparam int CTL = n / LINES;
        assign evt_hit[n] = evt_valid && (evt_line == LW'(n)) && ctl_ready[CTL];
        assign ack_hit[n] = ack_valid && (ack_line == LW'(n));
    end
endmodule

// File: rtl/irq_mode_regs.sv
module irq_mode_regs #(
    parameter int N_CTL = 2,
    parameter int LINES = 8,
    parameter logic [N_CTL*LINES-1:0] EDGE_ONLY = 16'h2107,
    localparam int NL = N_CTL * LINES,
    localparam int SW = (N_CTL > 1) ? $clog2(N_CTL) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SW-1:0]    wsel,
    input  logic [LINES-1:0] wdata,
    input  logic [SW-1:0]    rsel,
    output logic [LINES-1:0] rdata,
    output logic [NL-1:0]    level
);
    logic [LINES-1:0] mode_q [N_CTL];

    for (genvar c = 0; c < N_CTL; c++) begin : g_ctl
        localparam logic [LINES-1:0] LOCK = EDGE_ONLY[c*LINES +: LINES];
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_q[c] <= '0;
            end else if (we && (wsel == SW'(c))) begin
                mode_q[c] <= wdata & ~LOCK;
            end
        end
        assign level[c*LINES +: LINES] = mode_q[c];

        AST_EDGE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            (we && wsel == SW'(c)) |=> ((mode_q[c] & LOCK) == '0)); // R8
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < N_CTL; c++) begin
            if (rsel == SW'(c)) rdata = mode_q[c];
        end
    end
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
    import irq_cap_pkg::*;
#(
    parameter int CNT_W = 4,
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  ev_kind_e   kind,
    input  logic       level,
    input  logic       ack,
    output logic       req,
    output logic       err
);
    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic rise, uf, pos, set_req, clr_req;

    always_comb begin
        cnt_nxt = cnt_q;
        rise    = 1'b0;
        uf      = 1'b0;
        pos     = 1'b0;
        unique case (kind)
            EV_ASSERT: begin
                cnt_nxt = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1);
                rise    = (cnt_q == '0);
                pos     = 1'b1;
            end
            EV_DEASSERT: begin
                cnt_nxt = (cnt_q == '0) ? cnt_q : cnt_q - CNT_W'(1);
                uf      = (cnt_q == '0);
                pos     = (cnt_nxt != '0);
            end
            EV_PULSE: begin
                rise = (cnt_q == '0);
                pos  = 1'b1;
            end
            EV_NONE: ;
        endcase
        set_req = hit && (kind != EV_NONE) && (rise || (level && pos));
        clr_req = ack && ((cnt_q == '0) || !level) && !set_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            req   <= 1'b0;
            err   <= 1'b0;
        end else begin
            if (hit) cnt_q <= cnt_nxt;
            if (set_req)      req <= 1'b1;
            else if (clr_req) req <= 1'b0;
            if (hit && uf) err <= 1'b1;
        end
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && kind == EV_ASSERT && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R7
    AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && kind == EV_DEASSERT && cnt_q == '0) |=> (err && cnt_q == '0)); // R7
    AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && kind == EV_ASSERT && cnt_q == '0) |=> req); // R3
    AST_PULSE_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && kind == EV_PULSE) |=> $stable(cnt_q)); // R6
    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (level && req && cnt_q != '0) |=> req); // R5
endmodule

// File: rtl/irq_req_capture.sv
module irq_req_capture
    import irq_cap_pkg::*;
#(
    parameter int N_CTL = 2,
    parameter int LINES = 8,
    parameter int CNT_W = 4,
    parameter logic [N_CTL*LINES-1:0] EDGE_ONLY = 16'h2107,
    localparam int NL = N_CTL * LINES,
    localparam int LW = $clog2(NL),
    localparam int LB = $clog2(LINES),
    localparam int SW = (N_CTL > 1) ? $clog2(N_CTL) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CTL-1:0] ctl_ready,
    input  logic             evt_valid,
    input  logic [LW-1:0]    evt_line,
    input  logic [1:0]       evt_kind,
    input  logic             ack_valid,
    input  logic [LW-1:0]    ack_line,
    input  logic             mode_we,
    input  logic [SW-1:0]    mode_wsel,
    input  logic [LINES-1:0] mode_wdata,
    input  logic [SW-1:0]    mode_rsel,
    output logic [LINES-1:0] mode_rdata,
    output logic [NL-1:0]    req_o,
    output logic [NL-1:0]    uf_err_o
);
    logic [NL-1:0] evt_hit, ack_hit, level;
    ev_kind_e kind;
    assign kind = ev_kind_e'(evt_kind);

    irq_evt_decode #(.N_CTL(N_CTL), .LINES(LINES)) u_dec (
        .ctl_ready (ctl_ready),
        .evt_valid (evt_valid),
        .evt_line  (evt_line),
        .ack_valid (ack_valid),
        .ack_line  (ack_line),
        .evt_hit   (evt_hit),
        .ack_hit   (ack_hit)
    );

    irq_mode_regs #(.N_CTL(N_CTL), .LINES(LINES), .EDGE_ONLY(EDGE_ONLY)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mode_we),
        .wsel  (mode_wsel),
        .wdata (mode_wdata),
        .rsel  (mode_rsel),
        .rdata (mode_rdata),
        .level (level)
    );

    for (genvar n = 0; n < NL; n++) begin : g_cell
        irq_line_cell #(.CNT_W(CNT_W)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (evt_hit[n]),
            .kind  (kind),
            .level (level[n]),
            .ack   (ack_hit[n]),
            .req   (req_o[n]),
            .err   (uf_err_o[n])
        );
    end

    logic [LW-LB-1:0] evt_ctl;
    assign evt_ctl = evt_line[LW-1:LB];

    AST_NOT_READY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !ctl_ready[evt_ctl] && !ack_valid) |=> $stable(req_o)); // R10
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_valid && !ack_valid) |=> $stable(req_o)); // R2
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((uf_err_o & ~$past(uf_err_o)) == '0) || $past(evt_valid)); // R7
endmodule

// File: tb/tb_irq_req_capture.sv
module tb_irq_req_capture;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  ctl_ready;
    logic        evt_valid;
    logic [3:0]  evt_line;
    logic [1:0]  evt_kind;
    logic        ack_valid;
    logic [3:0]  ack_line;
    logic        mode_we;
    logic        mode_wsel;
    logic [7:0]  mode_wdata;
    logic        mode_rsel;
    logic [7:0]  mode_rdata;
    logic [15:0] req_o;
    logic [15:0] uf_err_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_req_capture dut (
        .clk(clk), .rst_n(rst_n), .ctl_ready(ctl_ready),
        .evt_valid(evt_valid), .evt_line(evt_line), .evt_kind(evt_kind),
        .ack_valid(ack_valid), .ack_line(ack_line),
        .mode_we(mode_we), .mode_wsel(mode_wsel), .mode_wdata(mode_wdata),
        .mode_rsel(mode_rsel), .mode_rdata(mode_rdata),
        .req_o(req_o), .uf_err_o(uf_err_o)
    );

    localparam logic [1:0] K_NO = 2'b00, K_AS = 2'b01, K_DE = 2'b10, K_PU = 2'b11;

    // {evt_valid, evt_line, evt_kind, ack_valid, ack_line, expected req_o}; all lines edge mode
    localparam logic [27:0] VEC [17] = '{
        {1'b1, 4'd3,  K_AS, 1'b0, 4'd0,  16'h0008}, // R3 rise from zero
        {1'b1, 4'd3,  K_AS, 1'b0, 4'd0,  16'h0008},
        {1'b0, 4'd0,  K_NO, 1'b1, 4'd3,  16'h0000}, // R11 edge consumed
        {1'b1, 4'd3,  K_AS, 1'b0, 4'd0,  16'h0000}, // R3 no rise at count>0
        {1'b1, 4'd3,  K_DE, 1'b0, 4'd0,  16'h0000},
        {1'b1, 4'd3,  K_DE, 1'b0, 4'd0,  16'h0000},
        {1'b1, 4'd3,  K_DE, 1'b0, 4'd0,  16'h0000}, // R4 falling edge
        {1'b1, 4'd10, K_PU, 1'b0, 4'd0,  16'h0400}, // R6 pulse at zero
        {1'b0, 4'd0,  K_NO, 1'b1, 4'd10, 16'h0000},
        {1'b1, 4'd15, K_AS, 1'b0, 4'd0,  16'h8000}, // R2 top line
        {1'b1, 4'd15, K_PU, 1'b0, 4'd0,  16'h8000},
        {1'b0, 4'd0,  K_NO, 1'b1, 4'd15, 16'h0000},
        {1'b1, 4'd15, K_PU, 1'b0, 4'd0,  16'h0000}, // R6 pulse at count 1
        {1'b1, 4'd15, K_DE, 1'b0, 4'd0,  16'h0000}, // R4
        {1'b1, 4'd0,  K_AS, 1'b1, 4'd0,  16'h0001}, // R11 raise wins
        {1'b0, 4'd0,  K_NO, 1'b1, 4'd0,  16'h0000},
        {1'b1, 4'd8,  K_NO, 1'b0, 4'd0,  16'h0000}  // R12 no-op kind
    };

    task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic idle();
        evt_valid = 1'b0; evt_kind = K_NO; evt_line = '0;
        ack_valid = 1'b0; ack_line = '0; mode_we = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic ev(input logic [3:0] ln, input logic [1:0] k);
        evt_valid = 1'b1; evt_line = ln; evt_kind = k;
        step();
    endtask

    task automatic ack(input logic [3:0] ln);
        ack_valid = 1'b1; ack_line = ln;
        step();
    endtask

    task automatic wmode(input logic sel, input logic [7:0] d);
        mode_we = 1'b1; mode_wsel = sel; mode_wdata = d;
        step();
    endtask

    initial begin
        #3_000_000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ctl_ready = 2'b11; mode_wsel = 1'b0; mode_wdata = '0; mode_rsel = 1'b0;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 req", req_o, 16'h0);
        chk("R1 err", uf_err_o, 16'h0);
        mode_rsel = 1'b0; #1; chk("R1 mode0", {8'h0, mode_rdata}, 16'h0);
        mode_rsel = 1'b1; #1; chk("R1 mode1", {8'h0, mode_rdata}, 16'h0);

        for (int i = 0; i < 17; i++) begin
            evt_valid = VEC[i][27]; evt_line = VEC[i][26:23]; evt_kind = VEC[i][22:21];
            ack_valid = VEC[i][20]; ack_line = VEC[i][19:16];
            step();
            chk($sformatf("R2/R3/R4/R6/R11/R12 row %0d", i), req_o, VEC[i][15:0]);
        end
        chk("R7 no underflow in table", uf_err_o, 16'h0);

        // R8 R9 forced edge bits and read select
        wmode(1'b0, 8'hFF);
        wmode(1'b1, 8'hFF);
        mode_rsel = 1'b0; #1; chk("R8 R9 mode0", {8'h0, mode_rdata}, 16'h00F8);
        mode_rsel = 1'b1; #1; chk("R8 R9 mode1", {8'h0, mode_rdata}, 16'h00DE);
        wmode(1'b0, 8'h10);
        wmode(1'b1, 8'h00);
        mode_rsel = 1'b0; #1; chk("R9 mode0 rewrite", {8'h0, mode_rdata}, 16'h0010);

        // R5 level line 4
        ev(4'd4, K_AS);  chk("R5 level assert", req_o, 16'h0010);
        ack(4'd4);       chk("R5 level held by count", req_o, 16'h0010);
        ev(4'd4, K_DE);  chk("R4 level deassert", req_o, 16'h0010);
        ack(4'd4);       chk("R11 level cleared at zero", req_o, 16'h0000);
        ev(4'd4, K_PU);  chk("R5 level pulse", req_o, 16'h0010);
        ack(4'd4);       chk("R6 pulse count zero", req_o, 16'h0000);

        // R7 underflow
        ev(4'd5, K_DE);  chk("R7 underflow flag", uf_err_o, 16'h0020);
        chk("R7 underflow no req", req_o, 16'h0000);
        ev(4'd5, K_AS);  chk("R7 count held at zero", req_o, 16'h0020);
        ack(4'd5);

        // R7 saturation at 15 on line 6
        for (int i = 0; i < 16; i++) begin
            ev(4'd6, K_AS);
            if (i == 0) ack(4'd6);
        end
        chk("R3 saturated no rise", req_o, 16'h0000);
        for (int i = 0; i < 15; i++) ev(4'd6, K_DE);
        chk("R7 saturation err", uf_err_o, 16'h0020);
        ev(4'd6, K_AS);  chk("R7 saturation count", req_o, 16'h0040);
        ack(4'd6);

        // R10 not-ready controller
        ctl_ready = 2'b01;
        ev(4'd9, K_AS);  chk("R10 ignored req", req_o, 16'h0000);
        ctl_ready = 2'b11;
        ev(4'd9, K_AS);  chk("R10 count untouched", req_o, 16'h0200);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule